// File: doc/BRIEF.md
# YUV to RGB Colour Space Converter

This block converts a stream of 8-bit Y, U, V pixels into 8-bit R, G, B pixels. Each output channel comes from its own row of a programmable 3x4 matrix: three multipliers applied to Y, U and V, plus a constant. The sum is rounded and clamped to the 0..255 range. After reset the matrix holds a BT.601 set that maps studio-range input (Y 16..235, chroma 16..240) onto full-range RGB.

Software writes the twelve coefficients and a bypass flag into shadow registers through a small write port. The shadow contents become active only on a frame-start pulse, so a frame is never converted with a mix of two coefficient sets. When bypass is active, an input that is already RGB passes through unchanged. In both modes the latency is the same, so stream timing never depends on the mode.

Pixels travel on a valid/ready stream through a three-stage pipeline. A single stall signal freezes every stage while the consumer holds ready low.

Top module: `csc_yuv2rgb`

## Requirements
- R1: After reset, `out_valid` is 0, bypass is off, and the active and shadow matrices both hold these raw values. G row (row 0): 0x4A7, 0x1E6F, 0x1CBF, 0x877. R row (row 1): 0x4A7, 0x000, 0x662, 0x3211. B row (row 2): 0x4A7, 0x812, 0x000, 0x2EB1.
- R2: A write with `cfg_we` high goes to register `cfg_addr`. Addresses 0..11 select row = addr / 4 and column = addr % 4. Row 0 drives G, row 1 drives R and row 2 drives B. Columns 0, 1 and 2 are the multipliers for Y, U and V, taken from `cfg_wdata[12:0]` as signed values with 10 fraction bits. Column 3 is the constant, taken from `cfg_wdata[13:0]` as a signed value with 4 fraction bits.
- R3: Each channel is computed as S = ky*Y + ku*U + kv*V + k0*64, all in units of 2^-10. The output is floor((S + 512) / 1024).
- R4: When that result is negative the channel outputs 0. When it is above 255 the channel outputs 255.
- R5: Address 12 bit 0 is the bypass flag. While bypass is active, `out_r`, `out_g` and `out_b` equal `in_c0`, `in_c1` and `in_c2` of the same pixel.
- R6: With `out_ready` held high, a pixel accepted in cycle n appears on the outputs in cycle n+3. This holds whether bypass is on or off.
- R7: Coefficient and bypass writes go only to the shadow registers. On a cycle with `frame_start` high, the shadow set as it stood before that cycle's write becomes active. A pixel accepted in that same cycle still uses the old set, and pixels accepted later use the new one.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output pixel stays stable. No pixel is lost, duplicated or reordered.
- R9: Writes to addresses 13..15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0..11 matrix, 12 bypass) |
| cfg_wdata | input | 16 | Register write data |
| frame_start | input | 1 | Pulse that makes the shadow set active |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Converter can accept a pixel |
| in_c0 | input | 8 | Y, or R in bypass |
| in_c1 | input | 8 | U, or G in bypass |
| in_c2 | input | 8 | V, or B in bypass |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the output pixel |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A wrong coefficient, a swapped row or a bad rounding constant shows up as a wrong channel value on the third cycle after the affected pixel is accepted. Sweeping many Y/U/V combinations exposes it on the first pixel whose products touch the faulty term. A faulty commit path shows up on the first pixel accepted after a frame-start pulse, which either keeps the old set or switches too early. A broken stall path shows up as a changed or dropped output within a cycle or two of the consumer deasserting ready.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W    = 8;
    localparam int MUL_W    = 13;
    localparam int MUL_FRAC = 10;
    localparam int OFS_W    = 14;
    localparam int OFS_FRAC = 4;
    localparam int NROWS    = 3;
    localparam int NCOLS    = 4;
    localparam int NREGS    = NROWS * NCOLS;
    localparam int CFG_AW   = 4;
    localparam int CFG_DW   = 16;
    localparam int BYP_ADDR = NREGS;
    localparam int ALIGN    = MUL_FRAC - OFS_FRAC;
    localparam int PROD_W   = PIX_W + MUL_W + 1;
    localparam int SUM_W    = PROD_W + 3;
    localparam int STAGES   = 3;

    localparam int ROW_G = 0;
    localparam int ROW_R = 1;
    localparam int ROW_B = 2;

    typedef logic signed [MUL_W-1:0] mul_t;
    typedef logic signed [OFS_W-1:0] ofs_t;

    typedef struct packed {
        mul_t ky;
        mul_t ku;
        mul_t kv;
        ofs_t k0;
    } row_coef_t;

    function automatic row_coef_t default_row(input int r);
        row_coef_t c;
        c.ky = 13'h04A7;
        case (r)
            ROW_G: begin
                c.ku = 13'h1E6F;
                c.kv = 13'h1CBF;
                c.k0 = 14'h0877;
            end
            ROW_R: begin
                c.ku = 13'h0000;
                c.kv = 13'h0662;
                c.k0 = 14'h3211;
            end
            default: begin
                c.ku = 13'h0812;
                c.kv = 13'h0000;
                c.k0 = 14'h2EB1;
            end
        endcase
        return c;
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CFG_AW-1:0]           wr_addr,
    input  logic [CFG_DW-1:0]           wr_data,
    input  logic                        commit,
    output row_coef_t [NROWS-1:0]       act_coef,
    output logic                        act_bypass
);
    typedef struct packed {
        row_coef_t [NROWS-1:0] shd;
        row_coef_t [NROWS-1:0] act;
        logic                  shd_byp;
        logic                  act_byp;
    } bank_t;

    bank_t d, q;

    logic [CFG_AW-3:0] sel_row;
    logic [1:0]        sel_col;

    assign sel_row = wr_addr[CFG_AW-1:2];
    assign sel_col = wr_addr[1:0];

    function automatic bank_t reset_bank();
        bank_t b;
        for (int r = 0; r < NROWS; r++) begin
            b.shd[r] = default_row(r);
            b.act[r] = default_row(r);
        end
        b.shd_byp = 1'b0;
        b.act_byp = 1'b0;
        return b;
    endfunction

    always_comb begin
        d = q;
        if (commit) begin
            d.act     = q.shd;
            d.act_byp = q.shd_byp;
        end
        if (wr_en) begin
            if (int'(wr_addr) < NREGS) begin
                case (sel_col)
                    2'd0:    d.shd[sel_row].ky = wr_data[MUL_W-1:0];
                    2'd1:    d.shd[sel_row].ku = wr_data[MUL_W-1:0];
                    2'd2:    d.shd[sel_row].kv = wr_data[MUL_W-1:0];
                    default: d.shd[sel_row].k0 = wr_data[OFS_W-1:0];
                endcase
            end else if (int'(wr_addr) == BYP_ADDR) begin
                d.shd_byp = wr_data[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= reset_bank();
        end else begin
            q <= d;
        end
    end

    assign act_coef   = q.act;
    assign act_bypass = q.act_byp;

    AST_ACT_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(q.act) && $stable(q.act_byp))); // R7

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) > BYP_ADDR)) |=> ($stable(q.shd) && $stable(q.shd_byp))); // R9
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] u,
    input  logic [PIX_W-1:0] v,
    input  row_coef_t        coef,
    output logic [PIX_W-1:0] res
);
    localparam int ROUND_I = 1 << (MUL_FRAC - 1);
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef struct packed {
        logic signed [PROD_W-1:0] py;
        logic signed [PROD_W-1:0] pu;
        logic signed [PROD_W-1:0] pv;
        logic signed [SUM_W-1:0]  ofs;
        logic signed [SUM_W-1:0]  sum;
        logic [PIX_W-1:0]         res;
    } row_st_t;

    row_st_t d, q;

    logic signed [SUM_W-1:0] rounded;
    logic signed [SUM_W-1:0] shifted;

    function automatic logic signed [PROD_W-1:0] mul(input logic [PIX_W-1:0] p, input mul_t k);
        logic [PROD_W-1:0] a;
        logic [PROD_W-1:0] b;
        a = {{(PROD_W-PIX_W){1'b0}}, p};
        b = {{(PROD_W-MUL_W){k[MUL_W-1]}}, k};
        return $signed(a * b);
    endfunction

    function automatic logic signed [SUM_W-1:0] sext(input logic signed [PROD_W-1:0] p);
        return {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

    always_comb begin
        rounded = q.sum + SUM_W'(ROUND_I);
        shifted = rounded >>> MUL_FRAC;
    end

    always_comb begin
        d = q;
        if (adv) begin
            d.py  = mul(y, coef.ky);
            d.pu  = mul(u, coef.ku);
            d.pv  = mul(v, coef.kv);
            d.ofs = {{(SUM_W-OFS_W-ALIGN){coef.k0[OFS_W-1]}}, coef.k0, {ALIGN{1'b0}}};
            d.sum = sext(q.py) + sext(q.pu) + sext(q.pv) + q.ofs;
            if (rounded[SUM_W-1]) begin
                d.res = '0;
            end else if (shifted > SUM_W'(PIX_MAX)) begin
                d.res = '1;
            end else begin
                d.res = shifted[PIX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign res = q.res;

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (q.sum < -SUM_W'(ROUND_I))) |=> (res == '0)); // R4

    AST_ROW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(res)); // R8
endmodule

// File: rtl/csc_yuv2rgb.sv
module csc_yuv2rgb
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int RAW_W = 3 * PIX_W;

    typedef struct packed {
        logic [STAGES-1:0]            vld;
        logic [STAGES-1:0]            byp;
        logic [STAGES-1:0][RAW_W-1:0] raw;
    } pipe_t;

    pipe_t d, q;

    row_coef_t [NROWS-1:0] act_coef;
    logic                  act_bypass;
    logic                  adv;
    logic [PIX_W-1:0]      row_res [NROWS];

    csc_coef_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_addr    (cfg_addr),
        .wr_data    (cfg_wdata),
        .commit     (frame_start),
        .act_coef   (act_coef),
        .act_bypass (act_bypass)
    );

    assign adv      = !q.vld[STAGES-1] || out_ready;
    assign in_ready = adv;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        csc_row u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .y     (in_c0),
            .u     (in_c1),
            .v     (in_c2),
            .coef  (act_coef[r]),
            .res   (row_res[r])
        );
    end

    always_comb begin
        d = q;
        if (adv) begin
            d.vld = {q.vld[STAGES-2:0], in_valid};
            d.byp = {q.byp[STAGES-2:0], act_bypass};
            d.raw[0] = {in_c0, in_c1, in_c2};
            for (int s = 1; s < STAGES; s++) begin
                d.raw[s] = q.raw[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.vld[STAGES-1];
    assign out_r = q.byp[STAGES-1] ? q.raw[STAGES-1][3*PIX_W-1:2*PIX_W] : row_res[ROW_R];
    assign out_g = q.byp[STAGES-1] ? q.raw[STAGES-1][2*PIX_W-1:PIX_W]   : row_res[ROW_G];
    assign out_b = q.byp[STAGES-1] ? q.raw[STAGES-1][PIX_W-1:0]         : row_res[ROW_B];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_r, out_g, out_b}))); // R8

    AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready); // R8

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready) && $past(in_valid && in_ready, 2)) |=> out_valid); // R6
endmodule

// File: tb/csc_yuv2rgb_tb.sv
module csc_yuv2rgb_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [15:0] cfg_wdata;
    logic       frame_start;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_c0, in_c1, in_c2;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_r, out_g, out_b;

    always #10 clk = ~clk;

    csc_yuv2rgb u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int chk_m = 0, fail_m = 0, chk_s = 0, fail_s = 0;
    int cyc = 0;
    bit done = 0;
    bit bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R1";

    int m_shd [12];
    int m_act [12];
    bit m_shd_byp = 0, m_act_byp = 0;

    logic [23:0] exp_q [$];
    string       tag_q [$];
    bit          prev_hold = 0;
    logic [23:0] prev_pix;

    function automatic int sx(input int raw, input int w);
        int m;
        m = raw & ((1 << w) - 1);
        return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
    endfunction

    function automatic int mrow(input int r, input int y, input int u, input int v);
        int s;
        int t;
        s = y * m_act[r*4] + u * m_act[r*4+1] + v * m_act[r*4+2] + m_act[r*4+3] * 64;
        t = (s + 512) >>> 10;
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        return t;
    endfunction

    // R1 reset values, decoded from their raw field encodings
    initial begin
        int raw [12] = '{'h4A7, 'h1E6F, 'h1CBF, 'h877,
                         'h4A7, 'h0,    'h662,  'h3211,
                         'h4A7, 'h812,  'h0,    'h2EB1};
        for (int i = 0; i < 12; i++) begin
            m_shd[i] = sx(raw[i], (i % 4 == 3) ? 14 : 13);
            m_act[i] = m_shd[i];
        end
    end

    // scoreboard and model of the register side
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_valid && in_ready) begin
                if (m_act_byp)
                    exp_q.push_back({in_c0, in_c1, in_c2});
                else
                    exp_q.push_back({8'(mrow(1, in_c0, in_c1, in_c2)),
                                     8'(mrow(0, in_c0, in_c1, in_c2)),
                                     8'(mrow(2, in_c0, in_c1, in_c2))});
                tag_q.push_back(cur_tag);
            end
            if (frame_start) begin
                for (int i = 0; i < 12; i++) m_act[i] = m_shd[i];
                m_act_byp = m_shd_byp;
            end
            if (cfg_we) begin
                if (cfg_addr < 12)
                    m_shd[cfg_addr] = sx(int'(cfg_wdata), (cfg_addr[1:0] == 2'd3) ? 14 : 13);
                else if (cfg_addr == 12)
                    m_shd_byp = cfg_wdata[0];
            end
            if (prev_hold) begin
                chk_s++;
                if (!out_valid || {out_r, out_g, out_b} != prev_pix) begin
                    fail_s++;
                    $display("FAIL R8 held output changed: act=%h/%0d exp=%h/1",
                             {out_r, out_g, out_b}, out_valid, prev_pix);
                end
            end
            prev_hold = out_valid && !out_ready;
            prev_pix  = {out_r, out_g, out_b};
            if (out_valid && out_ready) begin
                chk_s++;
                if (exp_q.size() == 0) begin
                    fail_s++;
                    $display("FAIL R8 unexpected pixel: act=%h exp=none", {out_r, out_g, out_b});
                end else begin
                    logic [23:0] e;
                    string tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if ({out_r, out_g, out_b} != e) begin
                        fail_s++;
                        $display("FAIL %s pixel rgb: act=%h exp=%h", tg, {out_r, out_g, out_b}, e);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", chk_m + chk_s + 1, fail_m + fail_s + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        chk_m++;
        if (!ok) begin
            fail_m++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int data);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 16'(data);
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic frame();
        frame_start = 1;
        @(posedge clk); #1;
        frame_start = 0;
    endtask

    task automatic send(input int a, input int b, input int c);
        bit ok;
        in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c); in_valid = 1;
        forever begin
            @(negedge clk); ok = in_ready;
            @(posedge clk); #1;
            if (ok) break;
        end
        in_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) begin
            @(posedge clk); #1;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic latency(input int a, input int b, input int c, input string tag);
        int n;
        drain();
        in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c); in_valid = 1;
        @(negedge clk);
        @(posedge clk); #1;
        in_valid = 0;
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!out_valid && n < 10);
        chk(n == 3, tag, n, 3);
        @(posedge clk); #1;
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frame_start = 0;
        in_valid = 0; in_c0 = 0; in_c1 = 0; in_c2 = 0; out_ready = 1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1, "R8 in_ready after reset", in_ready, 1);
        @(posedge clk); #1;

        // R6 latency in conversion mode
        latency(16, 128, 128, "R6 latency convert");

        // R1 default matrix along the luma axis
        cur_tag = "R1";
        for (int y = 0; y < 256; y++) send(y, 128, 128);
        drain();

        // R3 near-exhaustive grid through the default matrix
        cur_tag = "R3";
        for (int y = 0; y < 256; y += 15)
            for (int u = 0; u < 256; u += 15)
                for (int v = 0; v < 256; v += 15)
                    send(y, u, v);
        drain();

        // R4 clamp corners
        cur_tag = "R4";
        send(0, 0, 0); send(255, 255, 255); send(255, 0, 255);
        send(0, 255, 0); send(0, 128, 128); send(255, 128, 128);
        drain();

        // R2 new set in shadow: G=U, R=2Y-V+8, B=V/2-32
        wr(0, 'h0000); wr(1, 'h0400); wr(2, 'h0000); wr(3, 'h0000);
        wr(4, 'h0800); wr(5, 'h0000); wr(6, 'h1C00); wr(7, 'h0080);
        wr(8, 'h0000); wr(9, 'h0000); wr(10, 'h0200); wr(11, 'h3E00);

        // R7 old set still active until frame start
        cur_tag = "R7";
        send(100, 50, 200); send(16, 240, 16);
        drain();
        frame_start = 1;
        send(90, 60, 30);
        frame_start = 0;
        send(90, 60, 30);
        drain();

        cur_tag = "R2";
        for (int y = 0; y < 256; y += 17)
            for (int u = 0; u < 256; u += 17)
                for (int v = 0; v < 256; v += 17)
                    send(y, u, v);
        drain();

        // R9 high addresses are ignored
        wr(13, 'hFFFF); wr(14, 'h1FFF); wr(15, 'h0001);
        frame();
        cur_tag = "R9";
        for (int y = 0; y < 256; y += 51) send(y, 255 - y, y / 2);
        drain();

        // R5 bypass
        wr(12, 1);
        frame();
        latency(7, 8, 9, "R6 latency bypass");
        cur_tag = "R5";
        bp_mode = 1;
        for (int i = 0; i < 2000; i++) send(i % 256, (i * 7) % 256, (i * 13) % 256);
        drain();

        // R8 backpressure in conversion mode, default matrix restored
        wr(12, 0);
        for (int r = 0; r < 3; r++) begin
            wr(r * 4, 'h4A7);
        end
        wr(1, 'h1E6F); wr(2, 'h1CBF); wr(3, 'h877);
        wr(5, 'h0); wr(6, 'h662); wr(7, 'h3211);
        wr(9, 'h812); wr(10, 'h0); wr(11, 'h2EB1);
        frame();
        cur_tag = "R8";
        for (int i = 0; i < 3000; i++) send((i * 3) % 256, (i * 11) % 256, (i * 29) % 256);
        drain();
        bp_mode = 0;
        chk(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", chk_m + chk_s, fail_m + fail_s);
            $finish;
        end
    end
endmodule